// File: doc/BRIEF.md
# Directory Execute-Stage Update Control

This block is the combinational decision logic in the last stage of a directory coherence controller. It handles one message at a time. For that message it first works out the current coherence record of the addressed line: its state, its sharer vector and its owner. The record comes from one of three places. If the line is tracked as in flight, the transient tracking table supplies it. Otherwise a hit in the stable cache supplies it. For a replacement message, the victim data carried down the pipe supplies it. When none of these applies, the line is treated as not present.

The protocol table sits outside the block. It supplies two flags, whether the current state is stable and whether the next state is stable, and three action bits: info-update, store-data and invalidate-way. From these the block issues allocate, deallocate and update commands for the tracking table and for the stable cache. It also picks the tracking-table write index. Finally it decides whether the valid line in the chosen way must be pushed to the replacement queue as a victim. A line moves into the tracking table when it enters a transient state and back into the cache when it settles.

Top module: `dir_exec_ctrl`

## Requirements
- R1: The current record comes from the first source that applies, in this priority: tracking-table hit (`tt_hit`), then cache hit (`c_hit`), then replacement data (only when `is_repl` is 1).
- R2: When no source applies, `cur_state` is 0 (not present), `cur_sharers` is all zeros and `cur_owner` equals parameter `MEM_ID`.
- R3: `tt_alloc` is 1 exactly when `msg_valid`, `cur_stable` are 1 and `nxt_stable` is 0.
- R4: `tt_dealloc` is 1 exactly when `msg_valid` and `nxt_stable` are 1 and `cur_stable` is 0.
- R5: `tt_update` is 1 exactly when `msg_valid` and `info_upd` are 1 and both `cur_stable` and `nxt_stable` are 0.
- R6: `tt_wr_idx` equals `tt_free_idx` while `tt_alloc` is 1, and `tt_idx` otherwise.
- R7: `c_update` is 1 exactly when `msg_valid`, `cur_stable`, `nxt_stable` and `c_hit` are all 1 and at least one of `info_upd` or `store_data` is 1.
- R8: `c_dealloc` is 1 exactly when `tt_alloc` is 1 and `c_hit` is 1.
- R9: `c_alloc` is 1 when `msg_valid` and `nxt_stable` are 1 and at least one of `info_upd` or `store_data` is 1. It is held at 0 while `c_update` is 1, and also while `tt_dealloc` and `inval_way` are both 1.
- R10: `victim_push` is 1 exactly when all of these hold: `msg_valid` is 1, `way_valid` is 1, `c_alloc` or `c_update` is 1, `c_dealloc` is 0, `is_repl` is 0 and `c_hit` is 0.
- R11: While `msg_valid` is 0, all seven command outputs are 0, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| msg_valid | input | 1 | A message is being executed this cycle |
| is_repl | input | 1 | The message is a replacement |
| tt_hit | input | 1 | The addressed line is in the tracking table |
| tt_state | input | STATE_W | State held in the tracking table |
| tt_sharers | input | NTILES | Sharer vector held in the tracking table |
| tt_owner | input | OWNER_W | Owner held in the tracking table |
| tt_idx | input | IDX_W | Tracking-table index found in stage 1 |
| tt_free_idx | input | IDX_W | First free tracking-table index |
| c_hit | input | 1 | The addressed line hits in the stable cache |
| c_state | input | STATE_W | State read from the cache |
| c_sharers | input | NTILES | Sharer vector read from the cache |
| c_owner | input | OWNER_W | Owner read from the cache |
| way_valid | input | 1 | The selected cache way holds a valid line |
| rp_state | input | STATE_W | Replacement victim state |
| rp_sharers | input | NTILES | Replacement victim sharer vector |
| rp_owner | input | OWNER_W | Replacement victim owner |
| cur_stable | input | 1 | Protocol table: current state is stable |
| nxt_stable | input | 1 | Protocol table: next state is stable |
| info_upd | input | 1 | Protocol table: coherence info changes |
| store_data | input | 1 | Protocol table: line data is stored |
| inval_way | input | 1 | Protocol table: invalidate the cache way |
| cur_state | output | STATE_W | Selected current state |
| cur_sharers | output | NTILES | Selected current sharer vector |
| cur_owner | output | OWNER_W | Selected current owner |
| tt_alloc | output | 1 | Allocate a tracking-table entry |
| tt_dealloc | output | 1 | Free a tracking-table entry |
| tt_update | output | 1 | Rewrite a tracking-table entry |
| tt_wr_idx | output | IDX_W | Tracking-table entry to write |
| c_alloc | output | 1 | Allocate a cache line |
| c_dealloc | output | 1 | Free a cache line |
| c_update | output | 1 | Rewrite a cache line |
| victim_push | output | 1 | Push the way's line into the replacement queue |

## Verification
The block holds no state, so any fault in its logic shows up at the outputs in the same cycle as the inputs that trigger it. A wrong source priority gives the wrong record as soon as a tracking-table hit and a cache hit arrive together. A mistake in the stable/transient transition logic appears as a missing command or a doubled one, and it does so on the first message with that flag pair. A bad victim condition pushes a line on a hit, or on a cache handoff. Every cycle the bench compares each output against a behavioural model. Any divergence is therefore reported in the cycle where it first happens.

// File: rtl/dir_exec_ctrl.sv
module dir_exec_ctrl #(
  parameter int STATE_W = 3,
  parameter int NTILES  = 4,
  parameter int OWNER_W = 3,
  parameter int IDX_W   = 2,
  parameter int MEM_ID  = NTILES
) (
  input  logic               msg_valid,
  input  logic               is_repl,
  input  logic               tt_hit,
  input  logic [STATE_W-1:0] tt_state,
  input  logic [NTILES-1:0]  tt_sharers,
  input  logic [OWNER_W-1:0] tt_owner,
  input  logic [IDX_W-1:0]   tt_idx,
  input  logic [IDX_W-1:0]   tt_free_idx,
  input  logic               c_hit,
  input  logic [STATE_W-1:0] c_state,
  input  logic [NTILES-1:0]  c_sharers,
  input  logic [OWNER_W-1:0] c_owner,
  input  logic               way_valid,
  input  logic [STATE_W-1:0] rp_state,
  input  logic [NTILES-1:0]  rp_sharers,
  input  logic [OWNER_W-1:0] rp_owner,
  input  logic               cur_stable,
  input  logic               nxt_stable,
  input  logic               info_upd,
  input  logic               store_data,
  input  logic               inval_way,
  output logic [STATE_W-1:0] cur_state,
  output logic [NTILES-1:0]  cur_sharers,
  output logic [OWNER_W-1:0] cur_owner,
  output logic               tt_alloc,
  output logic               tt_dealloc,
  output logic               tt_update,
  output logic [IDX_W-1:0]   tt_wr_idx,
  output logic               c_alloc,
  output logic               c_dealloc,
  output logic               c_update,
  output logic               victim_push
);

  localparam logic [OWNER_W-1:0] MEM_OWNER = OWNER_W'(MEM_ID);

  always_comb begin
    if (tt_hit) begin
      cur_state   = tt_state;
      cur_sharers = tt_sharers;
      cur_owner   = tt_owner;
    end else if (c_hit) begin
      cur_state   = c_state;
      cur_sharers = c_sharers;
      cur_owner   = c_owner;
    end else if (is_repl) begin
      cur_state   = rp_state;
      cur_sharers = rp_sharers;
      cur_owner   = rp_owner;
    end else begin
      cur_state   = '0;
      cur_sharers = '0;
      cur_owner   = MEM_OWNER;
    end
  end

  logic writes_line;
  assign writes_line = info_upd | store_data;

  assign tt_alloc   = msg_valid &  cur_stable & ~nxt_stable;
  assign tt_dealloc = msg_valid & ~cur_stable &  nxt_stable;
  assign tt_update  = msg_valid & ~cur_stable & ~nxt_stable & info_upd;
  assign tt_wr_idx  = tt_alloc ? tt_free_idx : tt_idx;

  assign c_update  = msg_valid & cur_stable & nxt_stable & c_hit & writes_line;
  assign c_dealloc = tt_alloc & c_hit;
  assign c_alloc   = msg_valid & nxt_stable & writes_line
                     & ~(tt_dealloc & inval_way) & ~c_update;

  assign victim_push = msg_valid & way_valid & (c_alloc | c_update) & ~c_dealloc
                       & ~is_repl & ~c_hit;

endmodule

// File: rtl/dir_exec_chk.sv
module dir_exec_chk #(
  parameter int STATE_W = 3,
  parameter int NTILES  = 4,
  parameter int OWNER_W = 3,
  parameter int IDX_W   = 2,
  parameter int MEM_ID  = NTILES
) (
  input logic               msg_valid,
  input logic               is_repl,
  input logic               tt_hit,
  input logic [STATE_W-1:0] tt_state,
  input logic               c_hit,
  input logic               way_valid,
  input logic [STATE_W-1:0] cur_state,
  input logic [OWNER_W-1:0] cur_owner,
  input logic               tt_alloc,
  input logic               tt_dealloc,
  input logic               tt_update,
  input logic               c_alloc,
  input logic               c_dealloc,
  input logic               c_update,
  input logic               victim_push
);
  always_comb begin
    // R11
    idle_quiet_chk: assert (msg_valid || !(tt_alloc || tt_dealloc || tt_update ||
                            c_alloc || c_dealloc || c_update || victim_push));
    // R3
    tt_cmd_excl_chk: assert ($onehot0({tt_alloc, tt_dealloc, tt_update}));
    // R9
    alloc_vs_update_chk: assert (!(c_alloc && c_update));
    // R10
    push_on_miss_chk: assert (!victim_push || (!c_hit && !is_repl && way_valid));
    // R8
    dealloc_pair_chk: assert (!c_dealloc || (tt_alloc && c_hit));
    // R1
    tt_source_chk: assert (!tt_hit || cur_state == tt_state);
    // R2
    default_rec_chk: assert (tt_hit || c_hit || is_repl ||
                             (cur_state == '0 && cur_owner == OWNER_W'(MEM_ID)));
  end
endmodule

bind dir_exec_ctrl dir_exec_chk #(
  .STATE_W(STATE_W), .NTILES(NTILES), .OWNER_W(OWNER_W), .IDX_W(IDX_W), .MEM_ID(MEM_ID)
) u_chk (
  .msg_valid(msg_valid), .is_repl(is_repl), .tt_hit(tt_hit), .tt_state(tt_state),
  .c_hit(c_hit), .way_valid(way_valid), .cur_state(cur_state), .cur_owner(cur_owner),
  .tt_alloc(tt_alloc), .tt_dealloc(tt_dealloc), .tt_update(tt_update),
  .c_alloc(c_alloc), .c_dealloc(c_dealloc), .c_update(c_update),
  .victim_push(victim_push)
);

// File: tb/sim_dir_exec_ctrl.sv
`timescale 1ns/1ps
module sim_dir_exec_ctrl;
  localparam int SW = 3, NT = 4, OW = 3, IW = 2, MID = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic msg_valid, is_repl, tt_hit, c_hit, way_valid;
  logic cur_stable, nxt_stable, info_upd, store_data, inval_way;
  logic [SW-1:0] tt_state, c_state, rp_state, cur_state;
  logic [NT-1:0] tt_sharers, c_sharers, rp_sharers, cur_sharers;
  logic [OW-1:0] tt_owner, c_owner, rp_owner, cur_owner;
  logic [IW-1:0] tt_idx, tt_free_idx, tt_wr_idx;
  logic tt_alloc, tt_dealloc, tt_update, c_alloc, c_dealloc, c_update, victim_push;

  dir_exec_ctrl #(.STATE_W(SW), .NTILES(NT), .OWNER_W(OW), .IDX_W(IW), .MEM_ID(MID)) u0 (
    .msg_valid(msg_valid), .is_repl(is_repl), .tt_hit(tt_hit), .tt_state(tt_state),
    .tt_sharers(tt_sharers), .tt_owner(tt_owner), .tt_idx(tt_idx), .tt_free_idx(tt_free_idx),
    .c_hit(c_hit), .c_state(c_state), .c_sharers(c_sharers), .c_owner(c_owner),
    .way_valid(way_valid), .rp_state(rp_state), .rp_sharers(rp_sharers), .rp_owner(rp_owner),
    .cur_stable(cur_stable), .nxt_stable(nxt_stable), .info_upd(info_upd),
    .store_data(store_data), .inval_way(inval_way), .cur_state(cur_state),
    .cur_sharers(cur_sharers), .cur_owner(cur_owner), .tt_alloc(tt_alloc),
    .tt_dealloc(tt_dealloc), .tt_update(tt_update), .tt_wr_idx(tt_wr_idx),
    .c_alloc(c_alloc), .c_dealloc(c_dealloc), .c_update(c_update), .victim_push(victim_push));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int es, esh, eo, eidx;
    bit ta, td, tu, cu, cd, ca, vp, wr;
    if (tt_hit) begin es = tt_state; esh = tt_sharers; eo = tt_owner; end
    else if (c_hit) begin es = c_state; esh = c_sharers; eo = c_owner; end
    else if (is_repl) begin es = rp_state; esh = rp_sharers; eo = rp_owner; end
    else begin es = 0; esh = 0; eo = MID; end            // R2 default record
    wr = info_upd || store_data;
    ta = msg_valid && cur_stable && !nxt_stable;
    td = msg_valid && !cur_stable && nxt_stable;
    tu = msg_valid && !cur_stable && !nxt_stable && info_upd;
    eidx = ta ? tt_free_idx : tt_idx;
    cu = msg_valid && cur_stable && nxt_stable && c_hit && wr;
    cd = ta && c_hit;
    ca = msg_valid && nxt_stable && wr && !(td && inval_way) && !cu;
    vp = msg_valid && way_valid && (ca || cu) && !cd && !is_repl && !c_hit;
    cmp("R1 cur_state", cur_state, es);
    cmp("R1 cur_sharers", cur_sharers, esh);
    cmp("R2 cur_owner", cur_owner, eo);
    cmp("R3 tt_alloc", tt_alloc, ta);
    cmp("R4 tt_dealloc", tt_dealloc, td);
    cmp("R5 tt_update", tt_update, tu);
    cmp("R6 tt_wr_idx", tt_wr_idx, eidx);
    cmp("R7 c_update", c_update, cu);
    cmp("R8 c_dealloc", c_dealloc, cd);
    cmp("R9 c_alloc", c_alloc, ca);
    cmp("R10 victim_push", victim_push, vp);
    if (!msg_valid) cmp("R11 idle commands",
      {tt_alloc, tt_dealloc, tt_update, c_alloc, c_dealloc, c_update, victim_push}, 0);
  endtask

  task automatic drive_rand(input bit force_valid);
    msg_valid = force_valid ? 1'b1 : 1'($urandom_range(0, 3) != 0);
    is_repl = 1'($urandom); tt_hit = 1'($urandom); c_hit = 1'($urandom);
    way_valid = 1'($urandom); cur_stable = 1'($urandom); nxt_stable = 1'($urandom);
    info_upd = 1'($urandom); store_data = 1'($urandom); inval_way = 1'($urandom);
    tt_state = SW'($urandom); c_state = SW'($urandom); rp_state = SW'($urandom);
    tt_sharers = NT'($urandom); c_sharers = NT'($urandom); rp_sharers = NT'($urandom);
    tt_owner = OW'($urandom); c_owner = OW'($urandom); rp_owner = OW'($urandom);
    tt_idx = IW'($urandom); tt_free_idx = IW'($urandom);
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    @(posedge clk);
  endtask

  initial begin
    {msg_valid, is_repl, tt_hit, c_hit, way_valid, cur_stable, nxt_stable,
     info_upd, store_data, inval_way} = '0;
    {tt_state, c_state, rp_state, tt_sharers, c_sharers, rp_sharers} = '0;
    {tt_owner, c_owner, rp_owner, tt_idx, tt_free_idx} = '0;
    step();                                   // R2/R11 quiet start state
    // R1 priority: table hit beats cache hit
    drive_rand(1); tt_hit = 1; c_hit = 1; tt_state = 3'd5; c_state = 3'd2; step();
    // R1 cache beats replacement
    drive_rand(1); tt_hit = 0; c_hit = 1; is_repl = 1; step();
    // R2 nothing applies
    drive_rand(1); tt_hit = 0; c_hit = 0; is_repl = 0; step();
    // R3/R8 stable->transient with cache hit
    drive_rand(1); cur_stable = 1; nxt_stable = 0; c_hit = 1; step();
    // R4/R9 transient->stable with invalidate suppresses allocate
    drive_rand(1); cur_stable = 0; nxt_stable = 1; info_upd = 1; inval_way = 1; step();
    // R10 miss with valid way allocates and pushes victim
    drive_rand(1); cur_stable = 0; nxt_stable = 1; store_data = 1; inval_way = 0;
    c_hit = 0; tt_hit = 0; is_repl = 0; way_valid = 1; step();
    // R7 stable->stable hit
    drive_rand(1); cur_stable = 1; nxt_stable = 1; c_hit = 1; info_upd = 1; step();
    // R5 transient->transient
    drive_rand(1); cur_stable = 0; nxt_stable = 0; info_upd = 1; step();
    // R11 idle with everything else asserted
    drive_rand(1); msg_valid = 0; cur_stable = 1; nxt_stable = 1; info_upd = 1; step();
    for (int i = 0; i < 3000; i++) begin
      drive_rand(0); step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule